// File: doc/BRIEF.md
# Five-Digit Multiplexed BCD Display Scanner

This block time-shares one 4-bit BCD bus among five display digits. It raises one active-high digit-select line at a time and puts that digit's code on the bus. It walks from the most significant position down to the least significant one, and then starts again. The leading position stays lit for a few extra clocks, so the scan has an odd length overall. The BCD code for a slot is captured from the latched digit inputs in the clock where the slot begins. A latch update that lands in the middle of a slot therefore cannot disturb the bus.

A one-clock strobe marks the final clock of every complete scan for the status logic. An overrange flag is examined in that strobe clock. If the flag is set, the display goes dark: every select line is low and the bus is zero. It stays dark until a single-cycle pulse signals that reference integration has started. Scanning then resumes at the leading digit. Because of this hold, an overranged reading blinks. Any slot that begins while overrange is asserted also puts zero on the bus.

Top module: `disp_scan_top`

## Requirements
- R1: While rst_n is low, every digit select, the BCD bus and the strobe are 0. The first rising clock edge after release starts the D5 slot.
- R2: Outside the dark state exactly one digit select is high. Select bit k drives digit D(k+1), so bit 4 is D5, the most significant digit.
- R3: Slots run in the order D5, D4, D3, D2, D1, and then D5 again.
- R4: The D5 slot lasts SLOT_CLKS+LEAD_EXTRA clocks (201 by default). Every other slot lasts SLOT_CLKS clocks (200 by default).
- R5: During a slot the bus carries that digit's code. Digit D(k+1) is taken from digits_i[4k+3:4k], and bus bit 3 is the 8-weight bit. The bus changes on the same edge as the select lines.
- R6: The code for a slot is captured in the clock in which the slot starts. A change on digits_i after that point does not affect the bus until the slot of that digit comes round again.
- R7: strobe_o is high for exactly one clock, the last clock of the D1 slot, in every complete scan.
- R8: If overrange_i is high in the strobe clock, then from the next clock all selects are low and the bus is 0. This holds until a reference-start pulse arrives.
- R9: A ref_start_i pulse received in the dark state starts the D5 slot on the next clock, and a full scan follows.
- R10: While the block is scanning, ref_start_i has no effect on the selects, the bus or the slot timing.
- R11: A slot that begins while overrange_i is high puts 0 on the bus for its whole length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| digits_i | input | NUM_DIGITS*BCD_W | Latched BCD digits; nibble k is digit D(k+1) |
| overrange_i | input | 1 | Overrange flag from the conversion status |
| ref_start_i | input | 1 | Single-cycle pulse at the start of reference integration |
| digit_drv_o | output | NUM_DIGITS | Active-high digit selects, bit 4 = D5 |
| bcd_o | output | BCD_W | Shared BCD bus, bit 3 = 8-weight |
| strobe_o | output | 1 | One-clock pulse in the last clock of each scan |

## Verification
The bench builds the block with SLOT_CLKS=4 and LEAD_EXTRA=1, and keeps five digits. One scan then takes 21 clocks. This makes it practical to check every clock of several consecutive scans, the one-clock difference in the leading slot, and the exact strobe position. The blanking entry, the hold and the release each complete within a few dozen clocks. The sampling rule, the stray reference pulse and a reset asserted in the middle of a scan are all placed on known slot boundaries.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

  // Scanner operating state
  typedef enum logic [1:0] {
    SC_BOOT = 2'd0,  // first clock after reset, opens the D5 slot
    SC_RUN  = 2'd1,  // scanning digits
    SC_DARK = 2'd2   // blanked after an overranged scan
  } scan_state_e;

endpackage

// File: rtl/dscan_dwell.sv
module dscan_dwell #(
  parameter int SLOT_CLKS  = 200,
  parameter int LEAD_EXTRA = 1,
  parameter int CNT_W      = $clog2(SLOT_CLKS + LEAD_EXTRA + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,    // a slot is being shown
  input  logic lead_i,   // current slot is the leading digit
  output logic last_o    // final clock of the current slot
);

  localparam logic [CNT_W-1:0] LEAD_M1 = CNT_W'(SLOT_CLKS + LEAD_EXTRA - 1);
  localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(SLOT_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] len_m1;
  logic             cnt_en;
  logic             last;

  always_comb begin
    len_m1  = lead_i ? LEAD_M1 : BASE_M1;
    last    = run_i && (cnt_q == len_m1);
    cnt_en  = run_i;
    cnt_nxt = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign last_o = last;

  // R4
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= len_m1));

  // R4
  dwell_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (cnt_q == '0));

endmodule

// File: rtl/dscan_seq.sv
module dscan_seq
  import dscan_pkg::*;
#(
  parameter int NUM_DIGITS = 5,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_i,
  input  logic             ovr_i,
  input  logic             ref_start_i,
  output logic             run_o,
  output logic             dark_o,
  output logic [IDX_W-1:0] idx_o,      // 0 = leading digit
  output logic             load_o,     // a new slot starts next clock
  output logic [IDX_W-1:0] load_idx_o, // index of that slot
  output logic             strobe_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  scan_state_e      state_q, state_nxt;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             load;
  logic             st_en;

  always_comb begin
    state_nxt = state_q;
    idx_nxt   = idx_q;
    load      = 1'b0;
    unique case (state_q)
      SC_BOOT: begin
        load      = 1'b1;
        state_nxt = SC_RUN;
        idx_nxt   = '0;
      end
      SC_RUN: begin
        if (last_i) begin
          if (idx_q == LAST_IDX) begin
            if (ovr_i) begin
              state_nxt = SC_DARK;
              idx_nxt   = '0;
            end else begin
              load    = 1'b1;
              idx_nxt = '0;
            end
          end else begin
            load    = 1'b1;
            idx_nxt = idx_q + IDX_W'(1);
          end
        end
      end
      SC_DARK: begin
        if (ref_start_i) begin
          load      = 1'b1;
          state_nxt = SC_RUN;
          idx_nxt   = '0;
        end
      end
      default: begin
        state_nxt = SC_BOOT;
        idx_nxt   = '0;
      end
    endcase
    st_en = (state_nxt != state_q) || (idx_nxt != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_BOOT;
      idx_q   <= '0;
    end else if (st_en) begin
      state_q <= state_nxt;
      idx_q   <= idx_nxt;
    end
  end

  assign run_o      = (state_q == SC_RUN);
  assign dark_o     = (state_q == SC_DARK);
  assign idx_o      = idx_q;
  assign load_o     = load;
  assign load_idx_o = idx_nxt;
  assign strobe_o   = run_o && last_i && (idx_q == LAST_IDX);

  // R8
  dark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_o && !ref_start_i) |=> dark_o);

  // R9
  dark_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_o && ref_start_i) |=> (run_o && idx_o == '0));

  // R8
  ovr_enter_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && ovr_i) |=> dark_o);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/dscan_bcd.sv
module dscan_bcd #(
  parameter int NUM_DIGITS = 5,
  parameter int BCD_W      = 4,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic                        load_i,
  input  logic [IDX_W-1:0]            sel_i,   // slot index, 0 = leading
  input  logic                        ovr_i,
  input  logic                        run_i,
  output logic [BCD_W-1:0]            bcd_o
);

  logic [BCD_W-1:0] dig_a [NUM_DIGITS];
  logic [IDX_W-1:0] pos;
  logic [BCD_W-1:0] pick;
  logic [BCD_W-1:0] bcd_q, bcd_nxt;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_split
    assign dig_a[g] = digits_i[g*BCD_W +: BCD_W];
  end

  always_comb begin
    pos     = IDX_W'(NUM_DIGITS - 1) - sel_i;
    pick    = dig_a[pos];
    bcd_nxt = ovr_i ? '0 : pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcd_q <= '0;
    end else if (load_i) begin
      bcd_q <= bcd_nxt;
    end
  end

  assign bcd_o = run_i ? bcd_q : '0;

  // R6
  bcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(bcd_q));

  // R11
  bcd_ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && ovr_i) |=> (bcd_o == '0));

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top #(
  parameter int NUM_DIGITS = 5,
  parameter int BCD_W      = 4,
  parameter int SLOT_CLKS  = 200,
  parameter int LEAD_EXTRA = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic                        overrange_i,
  input  logic                        ref_start_i,
  output logic [NUM_DIGITS-1:0]       digit_drv_o,
  output logic [BCD_W-1:0]            bcd_o,
  output logic                        strobe_o
);

  localparam int IDX_W = $clog2(NUM_DIGITS);
  localparam int CNT_W = $clog2(SLOT_CLKS + LEAD_EXTRA + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  logic             run, dark, last, load, lead;
  logic [IDX_W-1:0] idx, load_idx;

  assign lead = (idx == '0);

  dscan_seq #(
    .NUM_DIGITS (NUM_DIGITS),
    .IDX_W      (IDX_W)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .last_i      (last),
    .ovr_i       (overrange_i),
    .ref_start_i (ref_start_i),
    .run_o       (run),
    .dark_o      (dark),
    .idx_o       (idx),
    .load_o      (load),
    .load_idx_o  (load_idx),
    .strobe_o    (strobe_o)
  );

  dscan_dwell #(
    .SLOT_CLKS  (SLOT_CLKS),
    .LEAD_EXTRA (LEAD_EXTRA),
    .CNT_W      (CNT_W)
  ) i_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .lead_i (lead),
    .last_o (last)
  );

  dscan_bcd #(
    .NUM_DIGITS (NUM_DIGITS),
    .BCD_W      (BCD_W),
    .IDX_W      (IDX_W)
  ) i_bcd (
    .clk      (clk),
    .rst_n    (rst_n),
    .digits_i (digits_i),
    .load_i   (load),
    .sel_i    (load_idx),
    .ovr_i    (overrange_i),
    .run_i    (run),
    .bcd_o    (bcd_o)
  );

  // Select bit k belongs to digit position k; slot index 0 is the top position.
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_drv
    assign digit_drv_o[k] = run && (idx == IDX_W'(NUM_DIGITS - 1 - k));
  end

  // R2
  drv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_drv_o));

  // R8
  dark_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dark |-> (digit_drv_o == '0 && bcd_o == '0));

  // R3
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last && idx != LAST_IDX) |=> (digit_drv_o == ($past(digit_drv_o) >> 1)));

  // R6
  mid_slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> ($stable(digit_drv_o) && $stable(bcd_o)));

  // R3
  wrap_to_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && !overrange_i) |=> digit_drv_o[NUM_DIGITS-1]);

endmodule

// File: tb/test_disp_scan_top.sv
module test_disp_scan_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM        = 5;
  localparam int SLOT       = 4;
  localparam int EXTRA      = 1;

  // {digits applied, expected bus sequence D5..D1}
  localparam logic [39:0] VEC [6] = '{
    {20'h12345, 20'h12345},
    {20'h98760, 20'h98760},
    {20'h00000, 20'h00000},
    {20'h99999, 20'h99999},
    {20'h50505, 20'h50505},
    {20'h08421, 20'h08421}
  };

  logic                clk;
  logic                rst_n;
  logic [NUM*4-1:0]    digits;
  logic                ovr;
  logic                ref_start;
  logic [NUM-1:0]      drv;
  logic [3:0]          bcd;
  logic                strb;

  int total = 0;
  int bad   = 0;

  disp_scan_top #(
    .NUM_DIGITS (NUM),
    .BCD_W      (4),
    .SLOT_CLKS  (SLOT),
    .LEAD_EXTRA (EXTRA)
  ) i_disp_scan_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .digits_i    (digits),
    .overrange_i (ovr),
    .ref_start_i (ref_start),
    .digit_drv_o (drv),
    .bcd_o       (bcd),
    .strobe_o    (strb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [19:0] act,
                     input logic [19:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Entered at the negedge of the first clock of a D5 slot.
  task automatic run_scan(input logic [19:0] exp, input logic [19:0] nxt,
                          input bit mid, input logic [19:0] mid_val, input bit poke);
    for (int p = 0; p < NUM; p++) begin
      int len;
      len = (p == 0) ? SLOT + EXTRA : SLOT;
      for (int c = 0; c < len; c++) begin
        logic [4:0] edrv;
        logic [3:0] ebcd;
        edrv = 5'b10000 >> p;
        ebcd = exp[(4-p)*4 +: 4];
        chk(drv == edrv, "R2/R3/R4 drive", 20'(drv), 20'(edrv));
        chk(bcd == ebcd, "R5/R6 bcd", 20'(bcd), 20'(ebcd));
        chk(strb == (p == NUM-1 && c == len-1), "R7 strobe", 20'(strb),
            20'(p == NUM-1 && c == len-1));
        if (mid && p == 0 && c == 1) digits = mid_val;
        ref_start = (poke && p == 2 && c == 0);
        if (p == NUM-1 && c == len-1) digits = nxt;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    digits = VEC[0][39:20];
    ovr = 1'b0;
    ref_start = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(drv == '0, "R1 reset drive", 20'(drv), 20'h0);
    chk(bcd == '0, "R1 reset bcd", 20'(bcd), 20'h0);
    chk(strb == 1'b0, "R1 reset strobe", 20'(strb), 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv == 5'b10000, "R1 first slot", 20'(drv), 20'h10);

    // Vector table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      run_scan(VEC[v][19:0], (v < 5) ? VEC[v+1][39:20] : VEC[v][39:20], 1'b0, 20'h0, 1'b0);
    end

    // R6: digits change mid D5 slot; D5 keeps old code, later slots new
    run_scan({VEC[5][19:16], 16'h7654}, 20'h37654, 1'b1, 20'h37654, 1'b0);

    // R10: stray reference pulse during scanning has no effect
    run_scan(20'h37654, 20'h37654, 1'b0, 20'h0, 1'b1);

    // R11 / R8: overrange raised during the scan
    ovr = 1'b1;
    run_scan(20'h30000, 20'h37654, 1'b0, 20'h0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      chk(drv == '0, "R8 dark drive", 20'(drv), 20'h0);
      chk(bcd == '0, "R8 dark bcd", 20'(bcd), 20'h0);
      chk(strb == 1'b0, "R8 dark strobe", 20'(strb), 20'h0);
      @(negedge clk);
    end
    // R9: release
    ref_start = 1'b1;
    ovr = 1'b0;
    @(negedge clk);
    ref_start = 1'b0;
    chk(drv == 5'b10000, "R9 release D5", 20'(drv), 20'h10);
    run_scan(20'h37654, 20'h37654, 1'b0, 20'h0, 1'b0);

    // R1: reset in mid scan
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(drv == '0, "R1 mid reset drive", 20'(drv), 20'h0);
    chk(bcd == '0, "R1 mid reset bcd", 20'(bcd), 20'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv == 5'b10000, "R1 restart D5", 20'(drv), 20'h10);
    chk(bcd == 4'h3, "R1 restart bcd", 20'(bcd), 20'h3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule